// File: doc/BRIEF.md
# Daisy-Chained Interrupt Acknowledge Vectoring

This block merges interrupt requests from a fixed set of peripherals onto one level-sensitive interrupt line towards a CPU and answers the CPU's acknowledge handshake with an 8-bit vector number. Each peripheral owns one stage of a serial acknowledge chain. A stage that holds a pending request claims the acknowledge and stops it there. A stage with no pending request passes the acknowledge on to the next stage. Stage 0 sits at the head of the chain and has the highest priority.

Each stage has a vector input that is programmed to a value in the range 0x20 to 0xFF. The CPU acknowledges with two pulses. The rising edge of the first pulse fixes the winning stage and its vector. The vector is driven, with a valid flag, only while the second pulse is high. In every other cycle the vector output is held at zero, so that no idle stage drives the data path. A request stays pending until its peripheral clears it after service. The acknowledge does not clear it, so the interrupt line stays high until the clear.

Top module: `irq_chain_vec`

## Requirements
- R1: When `req_i[i]` is high at a clock edge, stage i becomes pending, and `intr_o` is high from that edge on. When `clr_i[i]` is high at an edge, the pending bit is cleared at that edge. If both are high at the same edge, the clear wins.
- R2: At the first clock edge where `inta_i` is sampled high in the idle phase, the eligible pending stage with the lowest index wins. From that edge until the edge that ends the second pulse, `grant_o` is one-hot on that stage.
- R3: `intr_o` is high whenever at least one stage is eligible and pending. The acknowledge handshake does not lower it; only clears do.
- R4: `vec_valid_o` is high only while `inta_i` is high during the second pulse of the handshake, and it follows `inta_i` within the same cycle. It is low during the first pulse and during the gap between the pulses.
- R5: While `vec_valid_o` is high, `vec_o` equals the programmed vector of the winning stage. At all other times `vec_o` is 0x00.
- R6: A stage whose programmed vector is below 0x20 is not eligible. It does not raise `intr_o` and it does not block the acknowledge from lower-priority stages.
- R7: Requests and vector changes that arrive after the first pulse has been sampled do not change the grant or the vector of the handshake in progress.
- R8: If no stage is eligible and pending when the first pulse is sampled, `grant_o` stays zero and `vec_valid_o` stays low for the whole handshake.
- R9: After reset, no stage is pending, and `intr_o`, `grant_o`, `vec_valid_o` and `vec_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | N | Request line of each peripheral, level |
| clr_i | input | N | Service-done clear of each peripheral |
| vec_cfg_i | input | N*VW | Programmed vector of each stage; stage i occupies bits i*VW +: VW |
| intr_o | output | 1 | Combined interrupt request to the CPU |
| inta_i | input | 1 | Interrupt acknowledge from the CPU, active high, two pulses |
| grant_o | output | N | One-hot acknowledge kept by the winning stage |
| vec_o | output | VW | Vector number, zero when not valid |
| vec_valid_o | output | 1 | Vector valid, high during the second acknowledge pulse |

## Verification
A request that is driven between clock edges shows on `intr_o` right after the next rising edge. The bench therefore checks the interrupt line one falling edge after it drives the request. The grant appears after the edge that samples the first pulse, and the bench checks it at the falling edge that follows. The vector and its valid flag follow `inta_i` with no register in the path, so the bench checks them a short delay after it raises or lowers the second pulse, within the same cycle. The bench sweeps every request mask under two vector configurations and computes the expected winner arithmetically from the lowest eligible set bit.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;
    // lowest vector number a stage may legally use
    localparam int VEC_MIN = 32;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_FIRST  = 2'd1,
        PH_GAP    = 2'd2,
        PH_SECOND = 2'd3
    } ack_phase_e;
endpackage

// File: rtl/irq_chain_stage.sv
module irq_chain_stage
    import irq_chain_pkg::*;
#(
    parameter int VW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_i,
    input  logic          clr_i,
    input  logic [VW-1:0] vec_i,
    input  logic          ack_in_i,
    output logic          elig_o,
    output logic          hold_o
);
    typedef struct packed {
        logic pend;
    } stage_st_t;

    stage_st_t st_d, st_q;
    logic      vec_ok;

    always_comb begin
        st_d = st_q;
        if (req_i) st_d.pend = 1'b1;
        if (clr_i) st_d.pend = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vec_ok = (vec_i >= VW'(VEC_MIN));
    assign elig_o = st_q.pend & vec_ok;
    // the stage keeps the acknowledge only when it reaches it and is requesting
    assign hold_o = ack_in_i & elig_o;
endmodule

// File: rtl/irq_chain_vecmux.sv
module irq_chain_vecmux #(
    parameter int N  = 4,
    parameter int VW = 8
) (
    input  logic [N-1:0]    sel_i,
    input  logic [N*VW-1:0] vec_flat_i,
    output logic [VW-1:0]   vec_o
);
    always_comb begin
        vec_o = '0;
        for (int i = 0; i < N; i++) begin
            if (sel_i[i]) vec_o = vec_o | vec_flat_i[i*VW +: VW];
        end
    end
endmodule

// File: rtl/irq_chain_seq.sv
module irq_chain_seq
    import irq_chain_pkg::*;
#(
    parameter int N  = 4,
    parameter int VW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inta_i,
    input  logic [N-1:0]  hold_i,
    input  logic [VW-1:0] vec_sel_i,
    output logic [N-1:0]  grant_o,
    output logic          win_o,
    output logic [VW-1:0] vec_o,
    output ack_phase_e    phase_o
);
    typedef struct packed {
        ack_phase_e    ph;
        logic [N-1:0]  grant;
        logic          win;
        logic [VW-1:0] vec;
    } seq_st_t;

    seq_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        case (st_q.ph)
            PH_IDLE: begin
                if (inta_i) begin
                    st_d.ph    = PH_FIRST;
                    st_d.grant = hold_i;
                    st_d.win   = |hold_i;
                    st_d.vec   = vec_sel_i;
                end
            end
            PH_FIRST: begin
                if (!inta_i) st_d.ph = PH_GAP;
            end
            PH_GAP: begin
                if (inta_i) st_d.ph = PH_SECOND;
            end
            PH_SECOND: begin
                if (!inta_i) begin
                    st_d.ph    = PH_IDLE;
                    st_d.grant = '0;
                    st_d.win   = 1'b0;
                    st_d.vec   = '0;
                end
            end
            default: st_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign grant_o = st_q.grant;
    assign win_o   = st_q.win;
    assign vec_o   = st_q.vec;
    assign phase_o = st_q.ph;
endmodule

// File: rtl/irq_chain_vec.sv
module irq_chain_vec
    import irq_chain_pkg::*;
#(
    parameter int N  = 4,
    parameter int VW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    req_i,
    input  logic [N-1:0]    clr_i,
    input  logic [N*VW-1:0] vec_cfg_i,
    output logic            intr_o,
    input  logic            inta_i,
    output logic [N-1:0]    grant_o,
    output logic [VW-1:0]   vec_o,
    output logic            vec_valid_o
);
    logic [N-1:0]  ack_in;
    logic [N-1:0]  elig;
    logic [N-1:0]  hold;
    logic [VW-1:0] vec_sel;
    logic [VW-1:0] vec_lat;
    logic          win;
    ack_phase_e    phase;
    logic          second;

    assign ack_in[0] = 1'b1;

    for (genvar i = 0; i < N; i++) begin : g_stage
        irq_chain_stage #(.VW(VW)) u_stage (
            .clk      (clk),
            .rst_n    (rst_n),
            .req_i    (req_i[i]),
            .clr_i    (clr_i[i]),
            .vec_i    (vec_cfg_i[i*VW +: VW]),
            .ack_in_i (ack_in[i]),
            .elig_o   (elig[i]),
            .hold_o   (hold[i])
        );
        if (i < N - 1) begin : g_pass
            assign ack_in[i+1] = ack_in[i] & ~elig[i];
        end
    end

    irq_chain_vecmux #(.N(N), .VW(VW)) u_mux (
        .sel_i      (hold),
        .vec_flat_i (vec_cfg_i),
        .vec_o      (vec_sel)
    );

    irq_chain_seq #(.N(N), .VW(VW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .inta_i    (inta_i),
        .hold_i    (hold),
        .vec_sel_i (vec_sel),
        .grant_o   (grant_o),
        .win_o     (win),
        .vec_o     (vec_lat),
        .phase_o   (phase)
    );

    assign intr_o      = |elig;
    assign second      = (phase == PH_GAP) || (phase == PH_SECOND);
    assign vec_valid_o = inta_i & win & second;
    assign vec_o       = vec_valid_o ? vec_lat : '0;
endmodule

// File: rtl/irq_chain_vec_chk.sv
module irq_chain_vec_chk #(
    parameter int N  = 4,
    parameter int VW = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic [N-1:0]    clr_i,
    input logic [N*VW-1:0] vec_cfg_i,
    input logic            intr_o,
    input logic            inta_i,
    input logic [N-1:0]    grant_o,
    input logic [VW-1:0]   vec_o,
    input logic            vec_valid_o
);
    // R3: the line only drops after a clear or a change of configuration
    p_intr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (intr_o && (clr_i == '0)) |=> (intr_o || !$stable(vec_cfg_i)));

    // R2: at most one stage keeps the acknowledge
    p_grant_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));

    // R4: valid never shows without the acknowledge input
    p_valid_inta_r4: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid_o |-> inta_i);

    // R5: idle vector output is zero
    p_vec_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_valid_o |-> (vec_o == '0));

    // R6: a delivered vector is never reserved
    p_vec_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid_o |-> (vec_o >= VW'(32)));

    // R7: grant does not move while a handshake is in progress
    p_grant_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((|grant_o) && $past(|grant_o)) |-> $stable(grant_o));

    // R7: vector does not move across consecutive valid cycles
    p_vec_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid_o && $past(vec_valid_o)) |-> $stable(vec_o));
endmodule

bind irq_chain_vec irq_chain_vec_chk #(.N(N), .VW(VW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_i       (clr_i),
    .vec_cfg_i   (vec_cfg_i),
    .intr_o      (intr_o),
    .inta_i      (inta_i),
    .grant_o     (grant_o),
    .vec_o       (vec_o),
    .vec_valid_o (vec_valid_o)
);

// File: tb/irq_chain_vec_tb.sv
`timescale 1ns/1ps
module irq_chain_vec_tb;
    localparam int N  = 4;
    localparam int VW = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    req_i = '0;
    logic [N-1:0]    clr_i = '0;
    logic [N*VW-1:0] vec_cfg_i = '0;
    logic            inta_i = 1'b0;
    logic            intr_o;
    logic [N-1:0]    grant_o;
    logic [VW-1:0]   vec_o;
    logic            vec_valid_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    irq_chain_vec #(.N(N), .VW(VW)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req_i),
        .clr_i       (clr_i),
        .vec_cfg_i   (vec_cfg_i),
        .intr_o      (intr_o),
        .inta_i      (inta_i),
        .grant_o     (grant_o),
        .vec_o       (vec_o),
        .vec_valid_o (vec_valid_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [VW-1:0] cfg_vec(input int cfg, input int i);
        if (cfg == 1 && i == 1) return 8'h1F;
        return VW'(32 + 17 * i);
    endfunction

    function automatic logic [N-1:0] elig_mask(input int cfg);
        logic [N-1:0] m;
        for (int i = 0; i < N; i++) m[i] = (cfg_vec(cfg, i) >= 8'h20);
        return m;
    endfunction

    task automatic set_cfg(input int cfg);
        for (int i = 0; i < N; i++) vec_cfg_i[i*VW +: VW] = cfg_vec(cfg, i);
    endtask

    task automatic clear_all();
        @(negedge clk); clr_i = '1;
        @(negedge clk); clr_i = '0;
    endtask

    // full two-pulse handshake; exp_idx < 0 means no winner expected
    task automatic handshake(input int exp_idx, input logic [VW-1:0] exp_vec,
                             input logic [N-1:0] late_req, input int late_cfg);
        logic [N-1:0] eg;
        eg = (exp_idx < 0) ? '0 : (N'(1) << exp_idx);
        @(negedge clk); inta_i = 1'b1;
        @(negedge clk);
        chk("R2 grant after first pulse", grant_o, eg);
        chk("R4 no valid in first pulse", vec_valid_o, 0);
        inta_i = 1'b0;
        if (late_req != '0) begin
            req_i = late_req;
            set_cfg(late_cfg);
        end
        @(negedge clk);
        req_i = '0;
        chk("R4 no valid in gap", vec_valid_o, 0);
        chk("R7 grant held in gap", grant_o, eg);
        inta_i = 1'b1;
        #1;
        chk("R4 valid in second pulse", vec_valid_o, (exp_idx >= 0));
        chk("R5 vector value", vec_o, (exp_idx >= 0) ? exp_vec : 8'h00);
        @(negedge clk);
        chk("R8 R4 valid held", vec_valid_o, (exp_idx >= 0));
        inta_i = 1'b0;
        #1;
        chk("R4 valid drops with inta", vec_valid_o, 0);
        chk("R5 vector quiet", vec_o, 0);
        @(negedge clk);
        chk("R2 grant released", grant_o, 0);
    endtask

    initial begin
        #3_000_000;
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog act=1 exp=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        set_cfg(0);
        repeat (3) @(negedge clk);
        chk("R9 intr reset", intr_o, 0);
        chk("R9 grant reset", grant_o, 0);
        chk("R9 valid reset", vec_valid_o, 0);
        chk("R9 vec reset", vec_o, 0);
        rst_n = 1'b1;

        // sweep every mask under both configurations (R1 R2 R3 R5 R6)
        for (int cfg = 0; cfg < 2; cfg++) begin
            set_cfg(cfg);
            for (int m = 0; m < (1 << N); m++) begin
                logic [N-1:0] em;
                int win;
                em = N'(m) & elig_mask(cfg);
                win = -1;
                for (int i = N - 1; i >= 0; i--) if (em[i]) win = i;
                @(negedge clk); req_i = N'(m);
                @(negedge clk); req_i = '0;
                chk("R1 R6 intr after request", intr_o, (em != 0));
                handshake(win, (win >= 0) ? cfg_vec(cfg, win) : 8'h00, '0, cfg);
                chk("R3 intr kept after ack", intr_o, (em != 0));
                clear_all();
                chk("R1 intr after clear", intr_o, 0);
            end
        end

        // R1: clear beats a simultaneous request
        set_cfg(0);
        @(negedge clk); req_i = 4'b0100; clr_i = 4'b0100;
        @(negedge clk); req_i = '0; clr_i = '0;
        chk("R1 clear wins", intr_o, 0);

        // R7: higher-priority request and new vectors between pulses
        @(negedge clk); req_i = 4'b1000;
        @(negedge clk); req_i = '0;
        handshake(3, cfg_vec(0, 3), 4'b0001, 1);
        chk("R7 late request still pending", intr_o, 1);
        set_cfg(0);
        clear_all();

        // R3: clearing only the winner leaves the line high for the other
        @(negedge clk); req_i = 4'b0110;
        @(negedge clk); req_i = '0;
        handshake(1, cfg_vec(0, 1), '0, 0);
        @(negedge clk); clr_i = 4'b0010;
        @(negedge clk); clr_i = '0;
        chk("R3 intr held by remaining stage", intr_o, 1);
        handshake(2, cfg_vec(0, 2), '0, 0);
        clear_all();

        // R8: spurious acknowledge with only a reserved stage requesting
        set_cfg(1);
        @(negedge clk); req_i = 4'b0010;
        @(negedge clk); req_i = '0;
        chk("R6 reserved stage silent", intr_o, 0);
        handshake(-1, 8'h00, '0, 1);
        clear_all();

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule